// File: doc/BRIEF.md
# USB Receive PID and Token Decoder

This block sits behind a UTMI-style receive port and turns each incoming packet into decoded events. The first accepted byte of a packet is the packet identifier. Its low nibble names the type, and its high nibble must be the bitwise complement of the low nibble. The decoder sorts the packet into one of three classes: token (OUT, IN, SETUP, SOF), data (DATA0, DATA1, DATA2, MDATA) or unsupported (every handshake and special identifier). It rejects packets whose identifier check fails.

For OUT, IN and SETUP tokens, the device address and endpoint number are latched. For SOF, the 11-bit frame number is latched. A token updates these registers only when its CRC5 residual is correct. The latched values are announced with a one-cycle ready pulse.

For data packets, the decoder marks the start and the end of the packet. It forwards the payload bytes with a valid strobe. The two trailing CRC16 bytes are held back and never forwarded, so the consumer sees only payload. Malformed packets raise a one-cycle error pulse. Checking the CRC16 itself is left to the consumer.

Top module: `usb_pid_tok_dec`

## Requirements
- R1: After reset, `tok_ready`, `err_pulse`, `dat_start`, `dat_end` and `pay_valid` are low, and `tok_pid`, `tok_addr`, `tok_endp` and `frame_no` are zero.
- R2: A first byte whose bits [7:4] differ from the inverse of bits [3:0] gives exactly one `err_pulse` for the packet, with no `tok_ready`, `dat_start` or `dat_end`, and the latched token fields keep their values.
- R3: A well-formed identifier whose low nibble is none of 0001, 1001, 0101, 1101 (tokens) or 0011, 1011, 0111, 1111 (data) gives exactly one `err_pulse` and leaves every latched field unchanged.
- R4: For OUT (0001), IN (1001) and SETUP (1101), with token bytes b0 and b1 and a correct CRC5, the block gives one `tok_ready` pulse with `tok_addr` = b0[6:0], `tok_endp` = {b1[2:0], b0[7]} and `tok_pid` = the low nibble. `frame_no` is unchanged.
- R5: For SOF (0101) with a correct CRC5, the block gives one `tok_ready` pulse with `frame_no` = {b1[2:0], b0}. `tok_addr` and `tok_endp` are unchanged.
- R6: The CRC5 check runs the polynomial x^5+x^2+1, with the register preset to ones, over the 16 bits b0 then b1, each byte LSB first. It passes when the residual is 01100. On failure, `err_pulse` fires once, no `tok_ready` is given, and `tok_addr`, `tok_endp` and `frame_no` hold their values.
- R7: A token packet that ends before both token bytes have been accepted gives one `err_pulse` and no `tok_ready`.
- R8: A data packet gives exactly one `dat_start` pulse and, when `rx_active` falls, exactly one `dat_end` pulse.
- R9: The payload bytes of a data packet are every byte after the identifier except the last two. They appear on `pay_data` with `pay_valid`, once each and in arrival order.
- R10: Beyond `MAX_PAY` payload bytes, further bytes are not forwarded, and the packet gives one `err_pulse` at its end.
- R11: A byte is accepted only in a cycle where `rx_active` and `rx_valid` are both high. Bytes presented in any other cycle change no output.
- R12: Bytes after the second token byte are ignored. The token is decoded from the first two bytes only.
- R13: A data packet with fewer than two bytes after the identifier gives one `err_pulse` together with its `dat_end`, and forwards no payload.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Receive clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_data | input | 8 | Received byte |
| rx_valid | input | 1 | `rx_data` holds a byte this cycle |
| rx_active | input | 1 | High for the duration of a packet |
| tok_ready | output | 1 | One-cycle pulse: token fields freshly latched |
| tok_pid | output | 4 | Low nibble of the last accepted token |
| tok_addr | output | 7 | Latched device address |
| tok_endp | output | 4 | Latched endpoint number |
| frame_no | output | 11 | Latched frame number from SOF |
| err_pulse | output | 1 | One-cycle pulse on a malformed or unsupported packet |
| dat_start | output | 1 | One-cycle pulse when a data identifier is accepted |
| dat_end | output | 1 | One-cycle pulse at the end of a data packet |
| pay_valid | output | 1 | `pay_data` holds a payload byte |
| pay_data | output | 8 | Payload byte |

## Verification
The properties assume that `rx_active` drops for at least one cycle between packets. They also assume that end-of-packet is shown only by `rx_active` falling, not by a pattern on `rx_data`. The stimulus drives every packet as a contiguous `rx_active` window. It leaves at least two idle cycles after each window and inserts `rx_valid` gaps only inside the window. Bytes with `rx_active` low are presented only in a dedicated phase that checks they are ignored.

// File: rtl/usb_pd_pkg.sv
package usb_pd_pkg;

   typedef enum logic [1:0] {
      PC_TOKEN,
      PC_DATA,
      PC_UNSUP,
      PC_BAD
   } pid_class_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_TOK0,
      ST_TOK1,
      ST_TOKEND,
      ST_DATA,
      ST_DROP
   } dec_state_e;

   localparam logic [3:0] PID_OUT   = 4'b0001;
   localparam logic [3:0] PID_IN    = 4'b1001;
   localparam logic [3:0] PID_SOF   = 4'b0101;
   localparam logic [3:0] PID_SETUP = 4'b1101;
   localparam logic [3:0] PID_DATA0 = 4'b0011;
   localparam logic [3:0] PID_DATA1 = 4'b1011;
   localparam logic [3:0] PID_DATA2 = 4'b0111;
   localparam logic [3:0] PID_MDATA = 4'b1111;

   localparam logic [4:0] CRC5_POLY    = 5'b00101;
   localparam logic [4:0] CRC5_RESIDUE = 5'b01100;

endpackage

// File: rtl/usb_pd_pid_class.sv
module usb_pd_pid_class
   import usb_pd_pkg::*;
(
   input  logic [7:0] pid_byte,
   output pid_class_e pid_cls,
   output logic       pid_is_sof
);

   logic [3:0] low_n;
   logic       cmp_ok;

   assign low_n      = pid_byte[3:0];
   assign cmp_ok     = (pid_byte[7:4] == ~low_n);
   assign pid_is_sof = (low_n == PID_SOF);

   always_comb begin
      if (!cmp_ok) begin
         pid_cls = PC_BAD;
      end else begin
         unique case (low_n)
            PID_OUT, PID_IN, PID_SOF, PID_SETUP:     pid_cls = PC_TOKEN;
            PID_DATA0, PID_DATA1, PID_DATA2, PID_MDATA: pid_cls = PC_DATA;
            default:                                 pid_cls = PC_UNSUP;
         endcase
      end
   end

endmodule

// File: rtl/usb_pd_crc5_chk.sv
module usb_pd_crc5_chk
   import usb_pd_pkg::*;
#(
   parameter int FIELD_BITS = 16
) (
   input  logic [FIELD_BITS-1:0] bits_lsb_first,
   output logic                  crc_ok
);

   initial begin
      if (FIELD_BITS < 6) $error("usb_pd_crc5_chk: FIELD_BITS must cover the CRC");
   end

   logic [4:0] chain [0:FIELD_BITS];

   assign chain[0] = 5'b11111;

   for (genvar g = 0; g < FIELD_BITS; g++) begin : g_step
      logic fb;
      assign fb = chain[g][4] ^ bits_lsb_first[g];
      assign chain[g+1] = {chain[g][3:0], 1'b0} ^ (fb ? CRC5_POLY : 5'b00000);
   end

   assign crc_ok = (chain[FIELD_BITS] == CRC5_RESIDUE);

endmodule

// File: rtl/usb_pd_pay_pipe.sv
module usb_pd_pay_pipe #(
   parameter int HOLD    = 2,
   parameter int MAX_PAY = 1024
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       clr,
   input  logic       push,
   input  logic [7:0] din,
   output logic       pay_valid,
   output logic [7:0] pay_data,
   output logic       ovf
);

   localparam int CW = $clog2(MAX_PAY + 1);

   initial begin
      if (MAX_PAY < 1) $error("usb_pd_pay_pipe: MAX_PAY must be positive");
      if (HOLD < 0)    $error("usb_pd_pay_pipe: HOLD must not be negative");
   end

   logic          emit;
   logic [7:0]    edata;
   logic [CW-1:0] sent;
   logic          room;

   assign room = (sent < CW'(MAX_PAY));

   if (HOLD == 0) begin : g_pass
      assign emit  = push;
      assign edata = din;
   end else begin : g_hold
      localparam int FW = $clog2(HOLD + 1);
      logic [7:0]    sh [HOLD];
      logic [FW-1:0] fill;
      logic          full;

      assign full  = (fill == FW'(HOLD));
      assign emit  = push & full;
      assign edata = sh[HOLD-1];

      always_ff @(posedge clk) begin
         if (!rst_n || clr) begin
            fill <= '0;
         end else if (push && !full) begin
            fill <= fill + 1'b1;
         end
      end

      always_ff @(posedge clk) begin
         if (push) begin
            sh[0] <= din;
            for (int k = 1; k < HOLD; k++) sh[k] <= sh[k-1];
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pay_valid <= 1'b0;
         pay_data  <= '0;
         sent      <= '0;
         ovf       <= 1'b0;
      end else begin
         pay_valid <= 1'b0;
         if (clr) begin
            sent <= '0;
            ovf  <= 1'b0;
         end else if (emit) begin
            if (room) begin
               sent      <= sent + 1'b1;
               pay_valid <= 1'b1;
               pay_data  <= edata;
            end else begin
               ovf <= 1'b1;
            end
         end
      end
   end

endmodule

// File: rtl/usb_pid_tok_dec.sv
module usb_pid_tok_dec
   import usb_pd_pkg::*;
#(
   parameter int MAX_PAY    = 1024,
   parameter bit KEEP_CRC16 = 1'b0
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic [7:0]  rx_data,
   input  logic        rx_valid,
   input  logic        rx_active,
   output logic        tok_ready,
   output logic [3:0]  tok_pid,
   output logic [6:0]  tok_addr,
   output logic [3:0]  tok_endp,
   output logic [10:0] frame_no,
   output logic        err_pulse,
   output logic        dat_start,
   output logic        dat_end,
   output logic        pay_valid,
   output logic [7:0]  pay_data
);

   localparam int CRC16_BYTES = 2;
   localparam int HOLD        = KEEP_CRC16 ? 0 : CRC16_BYTES;

   initial begin
      if (MAX_PAY > 1024) $error("usb_pid_tok_dec: MAX_PAY above the bus limit");
   end

   dec_state_e st;
   pid_class_e cls;
   logic       is_sof;
   logic       take;
   logic       crc_ok;
   logic       sof_q;
   logic [3:0] pid_q;
   logic [7:0] b0_q;
   logic [1:0] seen;
   logic       pipe_clr;
   logic       pipe_push;
   logic       ovf;

   assign take = rx_active & rx_valid;

   usb_pd_pid_class i_cls (
      .pid_byte   (rx_data),
      .pid_cls    (cls),
      .pid_is_sof (is_sof)
   );

   usb_pd_crc5_chk #(.FIELD_BITS(16)) i_crc (
      .bits_lsb_first ({rx_data, b0_q}),
      .crc_ok         (crc_ok)
   );

   assign pipe_clr  = (st == ST_IDLE) && take && (cls == PC_DATA);
   assign pipe_push = (st == ST_DATA) && take;

   usb_pd_pay_pipe #(.HOLD(HOLD), .MAX_PAY(MAX_PAY)) i_pipe (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (pipe_clr),
      .push      (pipe_push),
      .din       (rx_data),
      .pay_valid (pay_valid),
      .pay_data  (pay_data),
      .ovf       (ovf)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st        <= ST_IDLE;
         tok_ready <= 1'b0;
         err_pulse <= 1'b0;
         dat_start <= 1'b0;
         dat_end   <= 1'b0;
         tok_pid   <= '0;
         tok_addr  <= '0;
         tok_endp  <= '0;
         frame_no  <= '0;
         sof_q     <= 1'b0;
         pid_q     <= '0;
         b0_q      <= '0;
         seen      <= '0;
      end else begin
         tok_ready <= 1'b0;
         err_pulse <= 1'b0;
         dat_start <= 1'b0;
         dat_end   <= 1'b0;
         unique case (st)
            ST_IDLE: begin
               if (take) begin
                  unique case (cls)
                     PC_TOKEN: begin
                        pid_q <= rx_data[3:0];
                        sof_q <= is_sof;
                        st    <= ST_TOK0;
                     end
                     PC_DATA: begin
                        dat_start <= 1'b1;
                        seen      <= '0;
                        st        <= ST_DATA;
                     end
                     default: begin
                        err_pulse <= 1'b1;
                        st        <= ST_DROP;
                     end
                  endcase
               end
            end
            ST_TOK0: begin
               if (!rx_active) begin
                  err_pulse <= 1'b1;
                  st        <= ST_IDLE;
               end else if (rx_valid) begin
                  b0_q <= rx_data;
                  st   <= ST_TOK1;
               end
            end
            ST_TOK1: begin
               if (!rx_active) begin
                  err_pulse <= 1'b1;
                  st        <= ST_IDLE;
               end else if (rx_valid) begin
                  if (crc_ok) begin
                     tok_ready <= 1'b1;
                     tok_pid   <= pid_q;
                     if (sof_q) begin
                        frame_no <= {rx_data[2:0], b0_q};
                     end else begin
                        tok_addr <= b0_q[6:0];
                        tok_endp <= {rx_data[2:0], b0_q[7]};
                     end
                  end else begin
                     err_pulse <= 1'b1;
                  end
                  st <= ST_TOKEND;
               end
            end
            ST_DATA: begin
               if (!rx_active) begin
                  dat_end <= 1'b1;
                  if (ovf || (seen < 2'(CRC16_BYTES))) err_pulse <= 1'b1;
                  st <= ST_IDLE;
               end else if (rx_valid && (seen != 2'd2)) begin
                  seen <= seen + 1'b1;
               end
            end
            default: begin
               if (!rx_active) st <= ST_IDLE;
            end
         endcase
      end
   end

endmodule

// File: rtl/usb_pd_checker.sv
module usb_pd_checker (
   input logic        clk,
   input logic        rst_n,
   input logic        rx_active,
   input logic        rx_valid,
   input logic        tok_ready,
   input logic        err_pulse,
   input logic        dat_start,
   input logic        dat_end,
   input logic        pay_valid,
   input logic [6:0]  tok_addr,
   input logic [3:0]  tok_endp,
   input logic [10:0] frame_no
);

   AST_TOK_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      tok_ready |=> !tok_ready); // R4

   AST_TOK_NOT_ERR: assert property (@(posedge clk) disable iff (!rst_n)
      !(tok_ready && err_pulse)); // R6

   AST_FIELDS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !tok_ready |=> ($stable(tok_addr) && $stable(tok_endp) && $stable(frame_no))
         || tok_ready); // R6

   AST_START_ALONE: assert property (@(posedge clk) disable iff (!rst_n)
      dat_start |-> !tok_ready && !err_pulse && !dat_end); // R8

   AST_END_AFTER_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      dat_end |-> $past(!rx_active)); // R8

   AST_PAY_ON_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
      pay_valid |-> $past(rx_active && rx_valid)); // R9

   AST_END_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      dat_end |=> !dat_end); // R8

endmodule

bind usb_pid_tok_dec usb_pd_checker i_pd_checker (
   .clk       (clk),
   .rst_n     (rst_n),
   .rx_active (rx_active),
   .rx_valid  (rx_valid),
   .tok_ready (tok_ready),
   .err_pulse (err_pulse),
   .dat_start (dat_start),
   .dat_end   (dat_end),
   .pay_valid (pay_valid),
   .tok_addr  (tok_addr),
   .tok_endp  (tok_endp),
   .frame_no  (frame_no)
);

// File: tb/test_usb_pid_tok_dec.sv
`timescale 1ns/1ps
module test_usb_pid_tok_dec;

   localparam int MAXP = 16;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  rx_data = '0;
   logic        rx_valid = 1'b0;
   logic        rx_active = 1'b0;
   logic        tok_ready, err_pulse, dat_start, dat_end, pay_valid;
   logic [3:0]  tok_pid, tok_endp;
   logic [6:0]  tok_addr;
   logic [10:0] frame_no;
   logic [7:0]  pay_data;

   always #2 clk = ~clk;

   usb_pid_tok_dec #(.MAX_PAY(MAXP), .KEEP_CRC16(1'b0)) i_usb_pid_tok_dec (
      .clk(clk), .rst_n(rst_n), .rx_data(rx_data), .rx_valid(rx_valid),
      .rx_active(rx_active), .tok_ready(tok_ready), .tok_pid(tok_pid),
      .tok_addr(tok_addr), .tok_endp(tok_endp), .frame_no(frame_no),
      .err_pulse(err_pulse), .dat_start(dat_start), .dat_end(dat_end),
      .pay_valid(pay_valid), .pay_data(pay_data)
   );

   int checks = 0;
   int errors = 0;
   int cycles = 0;
   int n_tok, n_err, n_ds, n_de, n_pay;
   logic [7:0] pay_buf [0:63];
   logic [7:0] pkt [0:31];
   int         plen;
   logic [6:0]  e_addr = '0;
   logic [3:0]  e_endp = '0;
   logic [3:0]  e_pid  = '0;
   logic [10:0] e_frame = '0;

   always @(negedge clk) begin
      cycles++;
      if (tok_ready) n_tok++;
      if (err_pulse) n_err++;
      if (dat_start) n_ds++;
      if (dat_end)   n_de++;
      if (pay_valid) begin
         if (n_pay < 64) pay_buf[n_pay] = pay_data;
         n_pay++;
      end
      if (cycles > 150000) begin
         errors++;
         $display("FAIL watchdog: actual %0d cycles, expected fewer", cycles);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic logic [4:0] crc5_gen(input logic [10:0] v);
      logic [4:0] c = 5'h1f;
      for (int i = 0; i < 11; i++) begin
         logic fb = c[4] ^ v[i];
         c = {c[3:0], 1'b0} ^ (fb ? 5'b00101 : 5'b00000);
      end
      return ~c;
   endfunction

   function automatic logic [7:0] tok_b1(input logic [10:0] v);
      logic [4:0] r = crc5_gen(v);
      logic [7:0] b;
      b[2:0] = v[10:8];
      for (int k = 0; k < 5; k++) b[3+k] = r[4-k];
      return b;
   endfunction

   task automatic send(input bit gaps);
      n_tok = 0; n_err = 0; n_ds = 0; n_de = 0; n_pay = 0;
      @(negedge clk);
      rx_active = 1'b1;
      for (int i = 0; i < plen; i++) begin
         if (gaps && ((i % 3) == 1)) begin
            rx_valid = 1'b0;
            rx_data  = 8'hA5;
            @(negedge clk);
         end
         rx_valid = 1'b1;
         rx_data  = pkt[i];
         @(negedge clk);
      end
      rx_valid  = 1'b0;
      rx_active = 1'b0;
      repeat (3) @(negedge clk);
   endtask

   task automatic fields_same(input string req);
      chk(tok_addr == e_addr, req, int'(tok_addr), int'(e_addr));
      chk(tok_endp == e_endp, req, int'(tok_endp), int'(e_endp));
      chk(frame_no == e_frame, req, int'(frame_no), int'(e_frame));
      chk(tok_pid == e_pid, req, int'(tok_pid), int'(e_pid));
   endtask

   task automatic token(input logic [3:0] p, input logic [10:0] v, input bit bad, input int extra, input bit gaps);
      pkt[0] = {~p, p};
      pkt[1] = v[7:0];
      pkt[2] = tok_b1(v) ^ (bad ? 8'h80 : 8'h00);
      for (int i = 0; i < extra; i++) pkt[3+i] = 8'(i * 29 + 3);
      plen = 3 + extra;
      send(gaps);
   endtask

   function automatic bit is_tok(input logic [3:0] p);
      return p == 4'd1 || p == 4'd9 || p == 4'd5 || p == 4'd13;
   endfunction
   function automatic bit is_dat(input logic [3:0] p);
      return p == 4'd3 || p == 4'd11 || p == 4'd7 || p == 4'd15;
   endfunction

   initial begin
      repeat (3) @(negedge clk);
      // R1: state right after reset
      chk(!tok_ready && !err_pulse && !dat_start && !dat_end && !pay_valid, "R1 pulses", 1, 0);
      chk(tok_addr == 0 && tok_endp == 0 && frame_no == 0 && tok_pid == 0, "R1 fields", int'(tok_addr), 0);
      rst_n = 1'b1;
      @(negedge clk);

      // Sweep every first byte: R2 R3 R4 R5 R8
      for (int b = 0; b < 256; b++) begin
         logic [7:0]  fb = 8'(b);
         logic [10:0] v  = 11'((b * 37 + 11) % 2048);
         pkt[0] = fb;
         pkt[1] = v[7:0];
         pkt[2] = tok_b1(v);
         plen = 3;
         send(b[0]);
         if (fb[7:4] != ~fb[3:0]) begin
            chk(n_err == 1 && n_tok == 0 && n_ds == 0 && n_de == 0, "R2 bad check", n_err, 1);
            fields_same("R2");
         end else if (is_tok(fb[3:0])) begin
            e_pid = fb[3:0];
            if (fb[3:0] == 4'd5) e_frame = v;
            else begin e_addr = v[6:0]; e_endp = v[10:7]; end
            chk(n_tok == 1 && n_err == 0, "R4 token pulse", n_tok, 1);
            fields_same(fb[3:0] == 4'd5 ? "R5" : "R4");
         end else if (is_dat(fb[3:0])) begin
            chk(n_ds == 1 && n_de == 1 && n_err == 0 && n_pay == 0, "R8 empty data", n_de, 1);
            fields_same("R8");
         end else begin
            chk(n_err == 1 && n_tok == 0 && n_ds == 0, "R3 unsupported", n_err, 1);
            fields_same("R3");
         end
      end

      // Field sweep with good and corrupt CRC: R4 R5 R6 R11
      for (int i = 0; i < 64; i++) begin
         logic [3:0]  p;
         logic [10:0] v = 11'((i * 61 + 5) % 2048);
         case (i % 4)
            0: p = 4'd1;
            1: p = 4'd9;
            2: p = 4'd13;
            default: p = 4'd5;
         endcase
         token(p, v, 1'b0, 0, i[0]);
         e_pid = p;
         if (p == 4'd5) e_frame = v; else begin e_addr = v[6:0]; e_endp = v[10:7]; end
         chk(n_tok == 1, "R11 token with gaps", n_tok, 1);
         fields_same(p == 4'd5 ? "R5" : "R4");
         token(p, ~v, 1'b1, 0, 1'b0);
         chk(n_tok == 0 && n_err == 1, "R6 crc fail", n_err, 1);
         fields_same("R6");
      end

      // R7: token cut short
      for (int s = 1; s <= 2; s++) begin
         pkt[0] = 8'hE1; pkt[1] = 8'h12;
         plen = s;
         send(1'b0);
         chk(n_err == 1 && n_tok == 0, "R7 short token", n_err, 1);
         fields_same("R7");
      end

      // R12: trailing bytes after a token
      token(4'd9, 11'h5A3, 1'b0, 4, 1'b1);
      e_pid = 4'd9; e_addr = 7'h23; e_endp = 4'hB;
      chk(n_tok == 1 && n_err == 0, "R12 extra bytes", n_tok, 1);
      fields_same("R12");

      // Data lengths: R8 R9 R10 R13
      for (int len = -2; len <= MAXP + 4; len++) begin
         int after = len + 2;
         int exp_pay = (len < 0) ? 0 : ((len > MAXP) ? MAXP : len);
         bit exp_err = (len < 0) || (len > MAXP);
         int bad = 0;
         pkt[0] = 8'h4B;
         for (int i = 0; i < after; i++) pkt[1+i] = 8'((len * 7 + i * 13) & 255);
         plen = 1 + after;
         send(len[0]);
         chk(n_ds == 1 && n_de == 1, "R8 markers", n_de, 1);
         chk(n_pay == exp_pay, len > MAXP ? "R10 count" : "R9 count", n_pay, exp_pay);
         chk(n_err == int'(exp_err), len < 0 ? "R13 error" : "R10 error", n_err, int'(exp_err));
         for (int i = 0; i < exp_pay && i < n_pay; i++)
            if (pay_buf[i] != pkt[1+i]) bad++;
         chk(bad == 0, "R9 payload order", bad, 0);
      end

      // R11: bytes outside a packet
      n_tok = 0; n_err = 0; n_ds = 0; n_de = 0; n_pay = 0;
      for (int i = 0; i < 10; i++) begin
         rx_valid = 1'b1;
         rx_data  = (i % 2 == 0) ? 8'hE1 : 8'hC3;
         @(negedge clk);
      end
      rx_valid = 1'b0;
      repeat (3) @(negedge clk);
      chk(n_tok + n_err + n_ds + n_de + n_pay == 0, "R11 idle bytes", n_tok + n_err + n_ds, 0);
      fields_same("R11");

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule